// File: doc/BRIEF.md
# Receive Frame Status Flag Checker

This block sits directly behind the frame decoder of a serial link receiver. On every word-clock cycle it takes one decoded frame class, the received flag bit, the received data word, the flag-handling mode and the word-width mode. It turns them into registered status outputs: data available, control available, error, and a fill-frame type bit, together with the outgoing data word and flag. A cycle in which none of data available, control available or error is raised marks a fill frame.

In check mode the flag bit must alternate strictly from one data frame to the next. A break in that alternation is reported on the same error output as an illegal frame class. In pass mode the flag bit is not checked and leaves the block as one more transparent data bit. The block also retimes an external start-up-complete input into an active-low link-ready output.

Top module: `frame_status_check`

## Requirements
- R1: A frame class of 5, 6 or 7 (not data, control or fill) raises errOut in the next cycle, with dataValid and ctrlValid low.
- R2: A data frame (class 0) that has no flag error raises dataValid in the next cycle. On a data frame dataOut takes the masked dataIn and flagOut takes flagIn. In every cycle that is not a data frame, flagOut is 0.
- R3: A control frame (class 1) raises ctrlValid in the next cycle and loads the masked dataIn into dataOut. On every frame that is neither data nor control, dataOut is 0.
- R4: A fill frame leaves dataValid, ctrlValid and errOut low. fillType is 0 for fill type 0 (class 2) and 1 for fill types 1a and 1b (classes 3 and 4). In every cycle that is not a fill frame, fillType is 0.
- R5: In check mode (flagPassMode=0), a data frame whose flag equals the flag of the previous, checked data frame is a flag error. A flag error raises errOut in the next cycle and keeps dataValid low.
- R6: The expected flag is reseeded from the received flag on the first data frame after reset, after any non-data frame, after any frame in pass mode, and after a flag error. A single corrupted flag therefore raises only one error.
- R7: In pass mode (flagPassMode=1), data frames are never flagged as errors, whatever their flag sequence.
- R8: With wideMode=1 all 20 bits of dataOut follow dataIn. With wideMode=0, dataOut[19:16] is 0.
- R9: linkReadyN equals the inverse of activeIn as it stood one cycle earlier.
- R10: While rst is high, every status output, dataOut and flagOut are cleared at the clock edge, and linkReadyN is driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| frameClass | input | 3 | Decoded frame class: 0 data, 1 control, 2 fill 0, 3 fill 1a, 4 fill 1b, 5-7 invalid |
| flagIn | input | 1 | Received flag bit |
| dataIn | input | 20 | Received data word |
| flagPassMode | input | 1 | 1: pass the flag through unchecked; 0: check alternation |
| wideMode | input | 1 | 1: 20-bit words; 0: 16-bit words |
| activeIn | input | 1 | Start-up complete indication |
| dataValid | output | 1 | Data frame received |
| ctrlValid | output | 1 | Control frame received |
| errOut | output | 1 | Illegal frame or flag alternation break |
| fillType | output | 1 | Fill frame type (0: type 0, 1: type 1a/1b) |
| flagOut | output | 1 | Received flag of the data frame |
| dataOut | output | 20 | Received word, masked to the active width |
| linkReadyN | output | 1 | Active-low link ready, registered |

## Verification
Two functions can land in the same cycle: a data frame arrives, and the alternation check flags it. When they meet, the error must take the place of data available, and the tracker must reseed so that the following frame is judged fresh. The bench provokes this with flag sequences that repeat a value, sweeps them against every frame class and both modes, and runs an independent model of the expected flag. Each cycle it checks errOut high, dataValid low and flagOut still carrying the received bit. A separate sequence counts the errors after one corrupted flag and expects exactly one.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int CLASS_W = 3;

  localparam logic [CLASS_W-1:0] CLS_DATA   = 3'd0;
  localparam logic [CLASS_W-1:0] CLS_CTRL   = 3'd1;
  localparam logic [CLASS_W-1:0] CLS_FILL0  = 3'd2;
  localparam logic [CLASS_W-1:0] CLS_FILL1A = 3'd3;
  localparam logic [CLASS_W-1:0] CLS_FILL1B = 3'd4;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic takeData;
    logic takeCtrl;
    logic frameErr;
    logic flagErr;
    logic isFill;
    logic fillHi;
  } strobe_t;
endpackage

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import fsc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [CLASS_W-1:0] frameClass,
  input  logic               flagIn,
  input  logic               flagPassMode,
  output strobe_t            strobes
);
  logic armed;
  logic expectFlag;
  logic isData, isCtrl, isFill0, isFill1, checkNow;

  always_comb begin
    isData   = (frameClass == CLS_DATA);
    isCtrl   = (frameClass == CLS_CTRL);
    isFill0  = (frameClass == CLS_FILL0);
    isFill1  = (frameClass == CLS_FILL1A) || (frameClass == CLS_FILL1B);
    checkNow = isData && !flagPassMode;

    strobes.takeData = isData;
    strobes.takeCtrl = isCtrl;
    strobes.isFill   = isFill0 || isFill1;
    strobes.fillHi   = isFill1;
    strobes.frameErr = !(isData || isCtrl || isFill0 || isFill1);
    strobes.flagErr  = checkNow && armed && (flagIn != expectFlag);
  end

  // expected-flag tracker: reseeds after reset, non-data, pass mode, error
  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      expectFlag <= 1'b0;
    end else if (checkNow && !strobes.flagErr) begin
      armed      <= 1'b1;
      expectFlag <= ~flagIn;
    end else begin
      armed      <= 1'b0;
      expectFlag <= expectFlag;
    end
  end
endmodule

// File: rtl/fsc_datapath.sv
module fsc_datapath
  import fsc_pkg::*;
#(
  parameter int DATA_W   = 20,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              flagIn,
  input  logic              wideMode,
  input  logic              activeIn,
  output logic              dataValid,
  output logic              ctrlValid,
  output logic              errOut,
  output logic              fillType,
  output logic              flagOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              linkReadyN
);
  logic [DATA_W-1:0] widthMask;
  logic [DATA_W-1:0] maskedData;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_mask
      if (gi < NARROW_W) begin : g_low
        assign widthMask[gi] = 1'b1;
      end else begin : g_high
        assign widthMask[gi] = wideMode;
      end
    end
  endgenerate

  assign maskedData = dataIn & widthMask;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataValid  <= 1'b0;
      ctrlValid  <= 1'b0;
      errOut     <= 1'b0;
      fillType   <= 1'b0;
      flagOut    <= 1'b0;
      dataOut    <= '0;
      linkReadyN <= 1'b1;
    end else begin
      dataValid  <= strobes.takeData && !strobes.flagErr;
      ctrlValid  <= strobes.takeCtrl;
      errOut     <= strobes.frameErr || strobes.flagErr;
      fillType   <= strobes.isFill && strobes.fillHi;
      flagOut    <= strobes.takeData ? flagIn : 1'b0;
      dataOut    <= (strobes.takeData || strobes.takeCtrl) ? maskedData : '0;
      linkReadyN <= ~activeIn;
    end
  end
endmodule

// File: rtl/frame_status_check.sv
module frame_status_check
  import fsc_pkg::*;
#(
  parameter int DATA_W   = 20,
  parameter int NARROW_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CLASS_W-1:0] frameClass,
  input  logic               flagIn,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic               flagPassMode,
  input  logic               wideMode,
  input  logic               activeIn,
  output logic               dataValid,
  output logic               ctrlValid,
  output logic               errOut,
  output logic               fillType,
  output logic               flagOut,
  output logic [DATA_W-1:0]  dataOut,
  output logic               linkReadyN
);
  strobe_t strobes;

  fsc_ctrl ctrl_i (
    .clk(clk), .rst(rst), .frameClass(frameClass), .flagIn(flagIn),
    .flagPassMode(flagPassMode), .strobes(strobes)
  );

  fsc_datapath #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .dataIn(dataIn), .flagIn(flagIn),
    .wideMode(wideMode), .activeIn(activeIn), .dataValid(dataValid),
    .ctrlValid(ctrlValid), .errOut(errOut), .fillType(fillType),
    .flagOut(flagOut), .dataOut(dataOut), .linkReadyN(linkReadyN)
  );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int DATA_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        frameClass,
  input logic              flagIn,
  input logic              flagPassMode,
  input logic              wideMode,
  input logic              activeIn,
  input logic              dataValid,
  input logic              ctrlValid,
  input logic              errOut,
  input logic              fillType,
  input logic              flagOut,
  input logic [DATA_W-1:0] dataOut,
  input logic              linkReadyN
);
  assert_invalid_err_R1: assert property (@(posedge clk) disable iff (rst)
    (frameClass > 3'd4) |=> (errOut && !dataValid && !ctrlValid));

  assert_status_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dataValid, ctrlValid, errOut}));

  assert_ctrl_valid_R3: assert property (@(posedge clk) disable iff (rst)
    (frameClass == 3'd1) |=> ctrlValid);

  assert_fill_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (frameClass == 3'd2) |=> (!dataValid && !ctrlValid && !errOut && !fillType));

  assert_pass_no_err_R7: assert property (@(posedge clk) disable iff (rst)
    (frameClass == 3'd0 && flagPassMode) |=> (dataValid && !errOut && flagOut == $past(flagIn)));

  assert_narrow_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !wideMode |=> (dataOut[DATA_W-1:DATA_W-4] == 4'd0));

  assert_link_ready_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (linkReadyN == !$past(activeIn)));
endmodule

bind frame_status_check fsc_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .frameClass(frameClass), .flagIn(flagIn),
  .flagPassMode(flagPassMode), .wideMode(wideMode), .activeIn(activeIn),
  .dataValid(dataValid), .ctrlValid(ctrlValid), .errOut(errOut),
  .fillType(fillType), .flagOut(flagOut), .dataOut(dataOut),
  .linkReadyN(linkReadyN)
);

// File: tb/frame_status_check_tb_top.sv
module frame_status_check_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  frameClass;
  logic        flagIn;
  logic [19:0] dataIn;
  logic        flagPassMode;
  logic        wideMode;
  logic        activeIn;
  logic        dataValid, ctrlValid, errOut, fillType, flagOut, linkReadyN;
  logic [19:0] dataOut;

  int total = 0;
  int bad = 0;
  int errSeen;

  // model state
  bit mArmed;
  bit mExpect;
  bit eDv, eCv, eErr, eFt, eFlag, eLr;
  logic [19:0] eData;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_status_check dut_i (
    .clk(clk), .rst(rst), .frameClass(frameClass), .flagIn(flagIn),
    .dataIn(dataIn), .flagPassMode(flagPassMode), .wideMode(wideMode),
    .activeIn(activeIn), .dataValid(dataValid), .ctrlValid(ctrlValid),
    .errOut(errOut), .fillType(fillType), .flagOut(flagOut),
    .dataOut(dataOut), .linkReadyN(linkReadyN)
  );

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compute expected outputs from the requirements, then apply one frame
  task automatic step(input logic [2:0] cls, input bit flg, input logic [19:0] d,
                      input bit pass, input bit wide, input bit act);
    bit isData, isCtrl, isFill, fErr;
    @(negedge clk);
    frameClass = cls; flagIn = flg; dataIn = d;
    flagPassMode = pass; wideMode = wide; activeIn = act;
    isData = (cls == 3'd0);
    isCtrl = (cls == 3'd1);
    isFill = (cls >= 3'd2 && cls <= 3'd4);
    fErr   = isData && !pass && mArmed && (flg == !mExpect);
    if (isData && !pass && !fErr) begin mArmed = 1; mExpect = !flg; end
    else mArmed = 0;
    eDv   = isData && !fErr;
    eCv   = isCtrl;
    eErr  = (!isData && !isCtrl && !isFill) || fErr;
    eFt   = isFill && (cls != 3'd2);
    eFlag = isData ? flg : 1'b0;
    eData = (isData || isCtrl) ? (wide ? d : {4'd0, d[15:0]}) : 20'd0;
    eLr   = !act;
    @(posedge clk);
    #1;
    if (errOut) errSeen++;
    if (cls > 3'd4) chk("R1 err", {19'd0, errOut}, {19'd0, eErr});
    else if (isData && !pass) chk("R5 err", {19'd0, errOut}, {19'd0, eErr});
    else chk("R7 err", {19'd0, errOut}, {19'd0, eErr});
    chk("R2 dataValid", {19'd0, dataValid}, {19'd0, eDv});
    chk("R2 flagOut", {19'd0, flagOut}, {19'd0, eFlag});
    chk("R3 ctrlValid", {19'd0, ctrlValid}, {19'd0, eCv});
    chk("R4 fillType", {19'd0, fillType}, {19'd0, eFt});
    if (wide) chk("R3 dataOut", dataOut, eData);
    else chk("R8 dataOut", dataOut, eData);
    chk("R9 linkReadyN", {19'd0, linkReadyN}, {19'd0, eLr});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; frameClass = 3'd0; flagIn = 0; dataIn = 20'hFFFFF;
    flagPassMode = 0; wideMode = 1; activeIn = 1;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 dataValid", {19'd0, dataValid}, 20'd0);
    chk("R10 ctrlValid", {19'd0, ctrlValid}, 20'd0);
    chk("R10 errOut", {19'd0, errOut}, 20'd0);
    chk("R10 fillType", {19'd0, fillType}, 20'd0);
    chk("R10 flagOut", {19'd0, flagOut}, 20'd0);
    chk("R10 dataOut", dataOut, 20'd0);
    chk("R10 linkReadyN", {19'd0, linkReadyN}, 20'd1);
    @(negedge clk);
    rst = 0;
    mArmed = 0; mExpect = 0;

    // R6 reseed after reset: first data frame never errors
    errSeen = 0;
    step(3'd0, 1, 20'h12345, 0, 1, 1);
    chk("R6 first data after reset", {19'd0, errOut}, 20'd0);

    // R6 single glitch: 1,0,1,1(glitch) ,0,1 -> exactly one error
    errSeen = 0;
    step(3'd0, 0, 20'h00001, 0, 1, 1);
    step(3'd0, 1, 20'h00002, 0, 1, 1);
    step(3'd0, 1, 20'h00003, 0, 1, 1);
    step(3'd0, 0, 20'h00004, 0, 1, 1);
    step(3'd0, 1, 20'h00005, 0, 1, 1);
    step(3'd0, 0, 20'h00006, 0, 1, 1);
    chk("R6 one error per glitch", errSeen, 1);

    // R6 reseed after non-data frame: repeat across a fill gap is fine
    step(3'd2, 0, 20'h0, 0, 1, 1);
    errSeen = 0;
    step(3'd0, 0, 20'hABCDE, 0, 1, 1);
    chk("R6 reseed after fill", errSeen, 0);

    // R7 pass mode: constant flag, no error
    errSeen = 0;
    for (int i = 0; i < 6; i++) step(3'd0, 1, 20'hF0F0F ^ i, 1, 1, 0);
    chk("R7 no error in pass mode", errSeen, 0);

    // R5 break in check mode
    step(3'd0, 0, 20'h11111, 0, 0, 0);
    step(3'd0, 0, 20'h22222, 0, 0, 0);
    chk("R5 repeated flag errors", {19'd0, errOut}, 20'd1);

    // sweep: every class x flag x mode x width x active, three passes
    for (int rep = 0; rep < 3; rep++)
      for (int c = 0; c < 8; c++)
        for (int f = 0; f < 2; f++)
          for (int p = 0; p < 2; p++)
            for (int w = 0; w < 2; w++)
              for (int a = 0; a < 2; a++)
                step(c[2:0], f[0], 20'((c * 20'h1F3A7) ^ (rep * 20'h9E37B) ^ (f << 19)),
                     p[0], w[0], a[0]);

    // sweep of data-only flag sequences in check mode
    for (int s = 0; s < 64; s++)
      for (int b = 0; b < 6; b++)
        step(3'd0, s[b], 20'(s * 4099 + b), 0, b[0], s[0]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule